// File: doc/BRIEF.md
# Power-Down Sequencer

This block sets the operating mode of a frequency-synthesis core. It reads a chip-enable pin and two programmed bits: a power-down request bit and a charge-pump tri-state bit. From these it drives an enable for the analog sections, a tri-state control for the associated pins, and a hold that keeps the reference and feedback dividers at their load point.

A power-down can be asynchronous or synchronous. An asynchronous power-down removes the analog enable in the same cycle. A synchronous power-down keeps the core running until a charge-pump pulse completes, then shuts it down. On return to normal operation the analog sections are enabled at once. The dividers stay held for `SETTLE_CYCLES` clock cycles and are then released together, so that counting resumes with the bias levels already settled.

All inputs are sampled in the system clock domain. The pulse-active indication comes from the phase detector.

Top module: `pd_sequencer`

## Requirements
- R1: After reset, and until normal operation is selected, `analog_en_o` is 0, `pin_hiz_o` is 1 and `div_hold_o` is 1.
- R2: While `chip_en_i` is 0, `analog_en_o` is 0 in the same cycle, whatever the values of `pdn_bit_i` and `tri_bit_i`.
- R3: From power-down, when `chip_en_i`=1 and `pdn_bit_i`=0 are applied, `analog_en_o` rises after the next clock edge. `tri_bit_i` is ignored in this case.
- R4: After `analog_en_o` rises, `div_hold_o` stays at 1 for exactly `SETTLE_CYCLES` clock cycles and then falls.
- R5: With `chip_en_i`=1, `pdn_bit_i`=1 and `tri_bit_i`=1, `analog_en_o` is 0 in the same cycle.
- R6: With `chip_en_i`=1, `pdn_bit_i`=1 and `tri_bit_i`=0 while running, `analog_en_o` stays 1 until `cp_busy_i` falls from 1 to 0. It is 0 after the clock edge that samples the fall.
- R7: If normal operation is selected again before the pulse completes, a pending synchronous power-down is cancelled. A later fall of `cp_busy_i` then leaves `analog_en_o`=1 and `div_hold_o`=0.
- R8: Any power-down request during the settling delay ends the delay at once. The next return to normal operation again holds the dividers for the full `SETTLE_CYCLES`.
- R9: `pin_hiz_o` is always the inverse of `analog_en_o`, and `div_hold_o` is 1 whenever `analog_en_o` is 0.
- R10: A synchronous request made while no pulse is active waits for the next pulse to start and then end before power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_en_i | input | 1 | Chip-enable pin, 1 = enabled |
| pdn_bit_i | input | 1 | Programmed power-down request, 1 = request |
| tri_bit_i | input | 1 | Programmed tri-state bit, selects asynchronous (1) or synchronous (0) power-down |
| cp_busy_i | input | 1 | Charge-pump pulse in progress |
| analog_en_o | output | 1 | Enable for the analog sections |
| pin_hiz_o | output | 1 | Tri-state control for the associated pins, 1 = high impedance |
| div_hold_o | output | 1 | Hold the dividers at their load point |

## Verification
A state register stuck in the running state shows as `analog_en_o` remaining high one edge after a pulse completes under a synchronous request. A stuck power-down state shows as `analog_en_o` failing to rise one edge after normal operation is selected. A settle counter that is wrong by a single count moves the fall of `div_hold_o` by one cycle, which the hold-window check catches exactly. A lost cancel or a pulse-end detector that fires on the wrong edge shows as an early or missing shutdown within one cycle of the pulse edge.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  typedef enum logic [1:0] {
    MODE_RUN      = 2'd0,
    MODE_SYNC_PD  = 2'd1,
    MODE_ASYNC_PD = 2'd2
  } pd_mode_e;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2,
    ST_DRAIN  = 2'd3
  } pd_state_e;
endpackage

// File: rtl/pd_mode_dec.sv
module pd_mode_dec
  import pd_seq_pkg::*;
(
  input  logic     chip_en_i,
  input  logic     pdn_bit_i,
  input  logic     tri_bit_i,
  output pd_mode_e mode_o
);
  always_comb begin
    if (!chip_en_i)      mode_o = MODE_ASYNC_PD;
    else if (!pdn_bit_i) mode_o = MODE_RUN;
    else if (tri_bit_i)  mode_o = MODE_ASYNC_PD;
    else                 mode_o = MODE_SYNC_PD;
  end
endmodule

// File: rtl/pd_pulse_end.sv
module pd_pulse_end (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic end_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= busy_i;
  end

  assign end_o = busy_q & ~busy_i;

  // one end event per pulse
  p_single_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> !end_o);
endmodule

// File: rtl/pd_settle_timer.sv
module pd_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);

  // abandoned delay restarts from zero
  p_cnt_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
  import pd_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chip_en_i,
  input  logic pdn_bit_i,
  input  logic tri_bit_i,
  input  logic cp_busy_i,
  output logic analog_en_o,
  output logic pin_hiz_o,
  output logic div_hold_o
);
  pd_mode_e  mode;
  pd_state_e st_q, st_d;
  logic      cp_end;
  logic      settle_done;

  pd_mode_dec u_dec (
    .chip_en_i (chip_en_i),
    .pdn_bit_i (pdn_bit_i),
    .tri_bit_i (tri_bit_i),
    .mode_o    (mode)
  );

  pd_pulse_end u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (cp_busy_i),
    .end_o  (cp_end)
  );

  pd_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q == ST_SETTLE),
    .done_o (settle_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:    if (mode == MODE_RUN) st_d = ST_SETTLE;
      ST_SETTLE: if (mode != MODE_RUN) st_d = ST_OFF;
                 else if (settle_done) st_d = ST_RUN;
      ST_RUN:    if (mode == MODE_ASYNC_PD) st_d = ST_OFF;
                 else if (mode == MODE_SYNC_PD) st_d = cp_end ? ST_OFF : ST_DRAIN;
      ST_DRAIN:  if (mode == MODE_RUN) st_d = ST_RUN;
                 else if (mode == MODE_ASYNC_PD || cp_end) st_d = ST_OFF;
      default:   st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_OFF;
    else         st_q <= st_d;
  end

  // asynchronous power-down gates the outputs in the same cycle
  assign analog_en_o = (st_q != ST_OFF) && (mode != MODE_ASYNC_PD);
  assign pin_hiz_o   = ~analog_en_o;
  assign div_hold_o  = (st_q == ST_OFF) || (st_q == ST_SETTLE) || !analog_en_o;

  p_ce_low_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chip_en_i |-> (!analog_en_o && pin_hiz_o && div_hold_o));

  p_async_bits_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_en_i && pdn_bit_i && tri_bit_i) |-> !analog_en_o);

  p_up_from_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OFF && mode == MODE_RUN) |=> st_q == ST_SETTLE);

  p_release_after_settle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && $past(st_q) == ST_SETTLE) |-> $past(settle_done));

  p_sync_defer_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_RUN || st_q == ST_DRAIN) && mode == MODE_SYNC_PD && !cp_end)
      |=> st_q != ST_OFF);

  p_cancel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DRAIN && mode == MODE_RUN) |=> st_q == ST_RUN);

  p_abort_settle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SETTLE && mode != MODE_RUN) |=> st_q == ST_OFF);

  p_hold_when_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !analog_en_o |-> div_hold_o);
endmodule

// File: tb/pd_sequencer_tb_top.sv
`timescale 1ns/1ps
module pd_sequencer_tb_top;
  localparam int unsigned N = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ce = 1'b0, pdn = 1'b0, tri_b = 1'b0, busy = 1'b0;
  logic aen, hiz, hold;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pd_sequencer #(.SETTLE_CYCLES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .chip_en_i(ce), .pdn_bit_i(pdn),
    .tri_bit_i(tri_b), .cp_busy_i(busy),
    .analog_en_o(aen), .pin_hiz_o(hiz), .div_hold_o(hold)
  );

  // {ce, pdn, tri, exp_now, exp_after_edge}, applied from running state
  localparam logic [4:0] VEC [8] = '{
    5'b000_00, 5'b001_00, 5'b010_00, 5'b011_00,
    5'b100_11, 5'b101_11, 5'b110_11, 5'b111_00
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_run();
    ce = 1'b1; pdn = 1'b0; tri_b = 1'b0; busy = 1'b0;
    repeat (N + 3) step();
  endtask

  initial begin
    repeat (3) step();
    chk("R1 aen", aen, 1'b0); chk("R1 hiz", hiz, 1'b1); chk("R1 hold", hold, 1'b1);
    rst_ni = 1'b1;
    repeat (2) step();
    chk("R1 aen idle", aen, 1'b0); chk("R1 hold idle", hold, 1'b1);

    // mode table from running state
    foreach (VEC[i]) begin
      go_run();
      chk("R4 running", hold, 1'b0);
      {ce, pdn, tri_b} = VEC[i][4:2];
      #1;
      chk("R2/R5 now", aen, VEC[i][1]);
      chk("R9 hiz", hiz, ~VEC[i][1]);
      step();
      chk("R6 after edge", aen, VEC[i][0]);
      chk("R9 hold", hold, ~VEC[i][0]);
    end

    // R3 and R4: power-up and exact settle window
    ce = 1'b0; step();
    ce = 1'b1; pdn = 1'b0; tri_b = 1'b1;
    #1 chk("R3 not yet", aen, 1'b0);
    step();
    chk("R3 enabled", aen, 1'b1);
    chk("R4 held", hold, 1'b1);
    for (int k = 1; k < N; k++) begin
      step(); chk("R4 still held", hold, 1'b1);
    end
    step(); chk("R4 released", hold, 1'b0);

    // R6: sync request during pulse
    busy = 1'b1; step();
    pdn = 1'b1; tri_b = 1'b0;
    repeat (3) begin step(); chk("R6 waits", aen, 1'b1); end
    busy = 1'b0;
    #1 chk("R6 before edge", aen, 1'b1);
    step();
    chk("R6 off", aen, 1'b0); chk("R6 hold", hold, 1'b1);

    // R10: sync request with no pulse active
    go_run();
    pdn = 1'b1; tri_b = 1'b0;
    repeat (3) begin step(); chk("R10 idle wait", aen, 1'b1); end
    busy = 1'b1;
    repeat (2) begin step(); chk("R10 pulse wait", aen, 1'b1); end
    busy = 1'b0; step();
    chk("R10 off", aen, 1'b0);

    // R7: cancel pending request
    go_run();
    busy = 1'b1; step();
    pdn = 1'b1; repeat (2) step();
    pdn = 1'b0; step();
    busy = 1'b0; step();
    chk("R7 still on", aen, 1'b1); chk("R7 not held", hold, 1'b0);
    repeat (2) step();
    chk("R7 stays on", aen, 1'b1);

    // R8: abort during settle, then full restart
    ce = 1'b0; step();
    ce = 1'b1; pdn = 1'b0; step(); step();
    chk("R8 in settle", hold, 1'b1);
    ce = 1'b0;
    #1 chk("R8 async abort", aen, 1'b0);
    step(); ce = 1'b1; step();
    chk("R8 restart on", aen, 1'b1);
    for (int k = 1; k < N; k++) begin
      step(); chk("R8 full hold", hold, 1'b1);
    end
    step(); chk("R8 released", hold, 1'b0);

    // R8: sync request during settle
    ce = 1'b0; step();
    ce = 1'b1; step(); step();
    pdn = 1'b1; tri_b = 1'b0;
    #1 chk("R8 sync before edge", aen, 1'b1);
    step(); chk("R8 sync abort", aen, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule